// File: doc/BRIEF.md
# Parallel 7/8 Polyphase Resampler

This block changes the sample rate of a wide parallel stream by the ratio 7/8. Each accepted clock brings a block of eight time-consecutive input samples on eight lanes. In the same clock the block yields seven resampled outputs on seven lanes. Input and output share one clock, and the output rate is 7/8 of the input rate. Conceptually the stream is upsampled by 7 (six zeros inserted after every input), low-pass filtered by a 28-tap prototype, then decimated by 8. Only the retained samples are ever computed.

Each output lane is a fixed polyphase branch. Lane k uses prototype phase k, which is the coefficients k, k+7, k+14 and k+21. The newest input it touches is sample k of the current block. A three-sample history taken from the previous block completes the tap windows of the low lanes. Products are summed at full precision, rounded, saturated to 16 bits and presented with a valid flag that trails the input valid by a fixed three cycles. Regrouping the seven output lanes into eight, coefficient design and sample capture belong to neighbouring blocks.

Top module: `poly78_resampler`

## Requirements
- R1: Input lane j (bits 16j+15..16j) carries sample 8b+j of accepted block b, so lane 0 is the oldest. Every accepted block produces exactly seven outputs. Output lane k (bits 16k+15..16k) carries output 7b+k.
- R2: Output 7b+k equals the serial result of three steps: insert six zeros after each input, convolve with coefficients h[0..27], and keep stream index 8(7b+k). This equals the sum over t=0..3 of h[k+7t]·x[8b+k−t], before scaling.
- R3: Samples from the previous block (up to three back) take part in the low lanes. Every sample before the first block after reset counts as zero.
- R4: Cycles with in_valid low are not consumed and do not advance the history. The outputs of a stream sent with gaps match those of the same stream sent without gaps.
- R5: out_valid is high exactly three clock cycles after a cycle with in_valid high, and low in every other cycle.
- R6: The full-precision sum S is scaled as floor((S + 16384) / 32768), which rounds to nearest with ties toward positive infinity.
- R7: A scaled result above 32767 is output as 32767. A result below −32768 is output as −32768.
- R8: While out_valid is low, out_data holds its previous value.
- R9: Reset is synchronous and active high. It forces out_valid to 0 and out_data to 0, and clears the history to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input block on in_data is valid this cycle |
| in_data | input | 128 | Eight signed 16-bit samples, lane 0 oldest |
| out_valid | output | 1 | out_data holds a new output block |
| out_data | output | 112 | Seven signed 16-bit resampled outputs, lane 0 oldest |

## Verification
The hardest case to reach from the ports is the carry of the last three samples of one block into the low lanes of the next. This carry has to be exercised across bubbles and across a reset in mid-stream. The stimulus sends multi-block streams with idle gaps of different lengths between blocks. It also resets while the history holds non-zero data and then sends new blocks. Every lane is compared with a serial upsample-filter-decimate model. A directed pair of impulses lands exactly on rounding ties of both signs.

// File: rtl/p78_pkg.sv
package p78_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int COEF_W_DEF   = 18;
    localparam int UP_DEF       = 7;
    localparam int DN_DEF       = 8;
    localparam int TPP_DEF      = 4;
    localparam int SHIFT_DEF    = 15;

    // Prototype low-pass, index 0 first; 4 taps per phase
    localparam logic signed [17:0] PROTO_COEF [28] = '{
        -18'sd1200, -18'sd2500, -18'sd3800, -18'sd4600, -18'sd4500, -18'sd3000,  18'sd0,
         18'sd4500,  18'sd10500, 18'sd17500, 18'sd25000, 18'sd32000, 18'sd37500, 18'sd40500,
         18'sd40500, 18'sd37500, 18'sd32000, 18'sd25000, 18'sd17500, 18'sd10500, 18'sd4500,
         18'sd0,    -18'sd3000, -18'sd4500, -18'sd4600, -18'sd3800, -18'sd2500, -18'sd1200
    };

    // Valid flags travelling down the three pipeline stages
    typedef struct packed {
        logic win;
        logic prod;
        logic out;
    } vpipe_t;

    // Prototype phase used by output lane k
    function automatic int lane_phase(int k, int up, int dn);
        return (k * dn) % up;
    endfunction

    // Newest input lane (within the current block) seen by output lane k
    function automatic int lane_newest(int k, int up, int dn);
        return (k * dn) / up;
    endfunction

    // Samples kept in the aligned window: carried history plus used current lanes
    function automatic int window_len(int up, int dn, int tpp);
        return (tpp - 1) + lane_newest(up - 1, up, dn) + 1;
    endfunction

endpackage

// File: rtl/p78_history.sv
module p78_history #(
    parameter int SW   = 16,
    parameter int DN   = 8,
    parameter int HIST = 3,
    parameter int WL   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DN*SW-1:0]   in_data,
    output logic [WL*SW-1:0]   window
);
    localparam int CUR = WL - HIST;

    logic [HIST*SW-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            window <= '0;
        end else if (load) begin
            window <= {in_data[CUR*SW-1:0], hist_q};
            hist_q <= in_data[DN*SW-1 -: HIST*SW];
        end
    end

    // R4: an idle cycle leaves the aligned window untouched
    p_bubble_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(window));

    // R3: the oldest window samples are the newest samples of the block before
    p_carry_r3: assert property (@(posedge clk) disable iff (rst)
        load ##1 load |=> window[HIST*SW-1:0] == $past(in_data[DN*SW-1 -: HIST*SW], 2));

endmodule

// File: rtl/p78_branch.sv
module p78_branch #(
    parameter int SW    = 16,
    parameter int CW    = 18,
    parameter int TPP   = 4,
    parameter int UP    = 7,
    parameter int PHASE = 0,
    parameter int SHIFT = 15,
    parameter logic signed [CW-1:0] COEF [UP*TPP] = p78_pkg::PROTO_COEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_prod,
    input  logic                 ld_out,
    input  logic [TPP*SW-1:0]    taps,
    output logic [SW-1:0]        out_s
);
    localparam int PW = SW + CW;
    localparam int AW = PW + $clog2(TPP) + 1;
    localparam logic signed [AW:0]   HALF = (AW + 1)'(1) <<< (SHIFT - 1);
    localparam logic signed [AW:0]   MAXV = (AW + 1)'(2 ** (SW - 1) - 1);
    localparam logic signed [AW:0]   MINV = (AW + 1)'(-(2 ** (SW - 1)));
    localparam logic signed [AW-1:0] NEG_LIM = AW'(-(2 ** SHIFT));

    logic signed [PW-1:0] prod_d [TPP];
    logic signed [PW-1:0] prod_q [TPP];
    logic signed [AW-1:0] acc;
    logic signed [AW:0]   rnd;
    logic [SW-1:0]        sat_d;

    // Tap t multiplies the sample t steps older than the newest one
    always_comb begin
        for (int t = 0; t < TPP; t++) begin
            prod_d[t] = PW'($signed(taps[(TPP - 1 - t)*SW +: SW])) * PW'(COEF[PHASE + UP*t]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < TPP; t++) prod_q[t] <= '0;
        end else if (ld_prod) begin
            for (int t = 0; t < TPP; t++) prod_q[t] <= prod_d[t];
        end
    end

    always_comb begin
        acc = '0;
        for (int t = 0; t < TPP; t++) acc = acc + AW'(prod_q[t]);
        rnd = ((AW + 1)'(acc) + HALF) >>> SHIFT;
        if (rnd > MAXV)      sat_d = MAXV[SW-1:0];
        else if (rnd < MINV) sat_d = MINV[SW-1:0];
        else                 sat_d = rnd[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         out_s <= '0;
        else if (ld_out) out_s <= sat_d;
    end

    // R7: clamping never flips the sign of a non-negative sum
    p_sign_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_out && acc >= 0) |=> !out_s[SW-1]);

    // R6: a sum below minus one output step rounds to a negative value
    p_sign_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_out && acc < NEG_LIM) |=> out_s[SW-1]);

    // R8: the lane output holds while no new result is loaded
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ld_out |=> $stable(out_s));

endmodule

// File: rtl/poly78_resampler.sv
module poly78_resampler #(
    parameter int SW    = p78_pkg::SAMPLE_W_DEF,
    parameter int CW    = p78_pkg::COEF_W_DEF,
    parameter int UP    = p78_pkg::UP_DEF,
    parameter int DN    = p78_pkg::DN_DEF,
    parameter int TPP   = p78_pkg::TPP_DEF,
    parameter int SHIFT = p78_pkg::SHIFT_DEF,
    parameter logic signed [CW-1:0] COEF [UP*TPP] = p78_pkg::PROTO_COEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DN*SW-1:0]   in_data,
    output logic               out_valid,
    output logic [UP*SW-1:0]   out_data
);
    import p78_pkg::*;

    localparam int HIST = TPP - 1;
    localparam int WL   = window_len(UP, DN, TPP);

    vpipe_t            vp;
    logic [WL*SW-1:0]  window;

    always_ff @(posedge clk) begin
        if (rst) vp <= '0;
        else     vp <= '{win: in_valid, prod: vp.win, out: vp.prod};
    end

    assign out_valid = vp.out;

    p78_history #(
        .SW(SW), .DN(DN), .HIST(HIST), .WL(WL)
    ) i_history (
        .clk(clk), .rst(rst), .load(in_valid), .in_data(in_data), .window(window)
    );

    for (genvar k = 0; k < UP; k++) begin : g_lane
        localparam int PH  = lane_phase(k, UP, DN);
        localparam int NEW = lane_newest(k, UP, DN);
        localparam int LO  = HIST + NEW - (TPP - 1);

        p78_branch #(
            .SW(SW), .CW(CW), .TPP(TPP), .UP(UP), .PHASE(PH), .SHIFT(SHIFT), .COEF(COEF)
        ) i_branch (
            .clk(clk), .rst(rst),
            .ld_prod(vp.win), .ld_out(vp.prod),
            .taps(window[LO*SW +: TPP*SW]),
            .out_s(out_data[k*SW +: SW])
        );
    end

    // R5: each accepted block appears exactly three cycles later
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R5: no output without an accepted block three cycles before
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

endmodule

// File: tb/test_poly78_resampler.sv
module test_poly78_resampler;

    localparam logic signed [17:0] H [28] = '{
        -18'sd1200, -18'sd2500, -18'sd3800, -18'sd4600, -18'sd4500, -18'sd3000,  18'sd0,
         18'sd4500,  18'sd10500, 18'sd17500, 18'sd25000, 18'sd32000, 18'sd37500, 18'sd40500,
         18'sd40500, 18'sd37500, 18'sd32000, 18'sd25000, 18'sd17500, 18'sd10500, 18'sd4500,
         18'sd0,    -18'sd3000, -18'sd4500, -18'sd4600, -18'sd3800, -18'sd2500, -18'sd1200
    };

    typedef struct packed {
        int kind;   // 0 impulse, 1 DC, 2 ramp, 3 alternating, 4 pseudo-random
        int amp;
        int nblk;
        int gap;
        int req;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TABLE [NVEC] = '{
        '{1,   1000, 3, 0, 1},
        '{2,   2000, 4, 0, 2},
        '{3,   9000, 3, 0, 2},
        '{4,      0, 4, 0, 2},
        '{4,      0, 4, 2, 4},
        '{1,  32767, 3, 1, 7},
        '{1, -32768, 3, 0, 7},
        '{3,  32767, 2, 3, 7}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          in_valid = 0;
    logic [127:0]  in_data = '0;
    logic          out_valid;
    logic [111:0]  out_data;

    int     xs   [512];
    int     expv [512];
    bit     exps [512];
    string  tagv [80];
    int     xc = 0;
    int     ob = 0;
    int     checks = 0;
    int     fails = 0;
    int unsigned lcg = 32'h1234_5678;
    logic [1:0]    vq = '0;
    logic [111:0]  last_out = '0;

    always #5 clk = ~clk;

    poly78_resampler #(.COEF(H)) i_poly78_resampler (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Serial reference: upsample by 7, filter, keep every 8th, scale and clamp
    function automatic int ref_out(int m, output bit sat);
        longint acc = 0;
        longint r;
        int n = 8 * m;
        for (int i = 0; i <= n / 7; i++) begin
            int t = n - 7 * i;
            if (t < 28) acc += longint'(H[t]) * longint'(xs[i]);
        end
        r = (acc + 64'sd16384) >>> 15;
        sat = (r > 32767) || (r < -32768);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic send_block(int kind, int amp, string tag);
        int b;
        bit s;
        for (int j = 0; j < 8; j++) begin
            int v;
            case (kind)
                0: v = (j == 0) ? amp : 0;
                1: v = amp;
                2: v = (((xc + j) % 16) - 8) * (amp / 2);
                3: v = (j % 2 == 1) ? -amp : amp;
                default: begin
                    lcg = lcg * 32'd1103515245 + 32'd12345;
                    v = int'($signed(lcg[30:15]));
                end
            endcase
            xs[xc + j] = v;
            in_data[j*16 +: 16] = 16'(v);
        end
        in_valid = 1;
        b = xc / 8;
        xc += 8;
        for (int k = 0; k < 7; k++) begin
            expv[7*b + k] = ref_out(7*b + k, s);
            exps[7*b + k] = s;
        end
        tagv[b] = tag;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic do_reset;
        rst = 1;
        in_valid = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        xc = 0;
    endtask

    task automatic check_val(string tag, int got, int e);
        checks++;
        if (got != e) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, e);
        end
    endtask

    // Output monitor, sampling 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst) begin
            ob = 0;
            vq = '0;
            last_out = '0;
        end else begin
            if (out_valid || vq[1]) begin
                checks++;
                if (out_valid !== vq[1]) begin
                    fails++;
                    $display("FAIL R5 out_valid: got %0b expected %0b", out_valid, vq[1]);
                end
            end
            if (out_valid) begin
                for (int k = 0; k < 7; k++) begin
                    int got;
                    int e;
                    string tg;
                    got = int'($signed(out_data[k*16 +: 16]));
                    e   = expv[7*ob + k];
                    tg  = exps[7*ob + k] ? "R7" : ((ob == 0) ? "R3" : tagv[ob]);
                    checks++;
                    if (got != e) begin
                        fails++;
                        $display("FAIL %s lane %0d block %0d: got %0d expected %0d", tg, k, ob, got, e);
                    end
                end
                ob++;
                last_out = out_data;
            end else begin
                checks++;
                if (out_data !== last_out) begin
                    fails++;
                    $display("FAIL R8 hold: got %h expected %h", out_data, last_out);
                end
            end
            vq = {vq[0], in_valid};
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        check_val("R9 out_valid", int'(out_valid), 0);
        check_val("R9 out_data", int'(out_data != '0), 0);

        // R6: impulse products landing on exact half steps of both signs
        send_block(0, -4096, "R6");
        repeat (2) @(negedge clk);
        check_val("R6 lane0", int'($signed(out_data[15:0])), 150);
        check_val("R6 lane1 tie negative", int'($signed(out_data[31:16])), -1312);
        check_val("R6 lane2", int'($signed(out_data[47:32])), -4000);
        check_val("R6 lane3", int'($signed(out_data[63:48])), 575);
        send_block(0, 4096, "R6");
        repeat (2) @(negedge clk);
        check_val("R6 R3 lane0", int'($signed(out_data[15:0])), -150);
        check_val("R6 lane1 tie positive", int'($signed(out_data[31:16])), 1313);
        check_val("R6 lane2", int'($signed(out_data[47:32])), 4000);
        check_val("R6 lane3", int'($signed(out_data[63:48])), -575);

        // R1 R2 R4 R7: table of stimulus patterns
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            case (TABLE[v].req)
                1:       tag = "R1";
                4:       tag = "R4";
                7:       tag = "R7";
                default: tag = "R2 R6";
            endcase
            for (int n = 0; n < TABLE[v].nblk; n++) begin
                send_block(TABLE[v].kind, TABLE[v].amp, tag);
                repeat (TABLE[v].gap) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);

        // R3 R9: reset with a non-zero history, then restart the stream
        do_reset();
        check_val("R9 out_valid after mid reset", int'(out_valid), 0);
        check_val("R9 out_data after mid reset", int'(out_data != '0), 0);
        send_block(1, 3000, "R3");
        send_block(4, 0, "R3");
        repeat (6) @(negedge clk);

        report();
    end

endmodule